// File: doc/BRIEF.md
# Lock-Aware Fully Associative Translation Buffer

This block holds a set of translation slots (64 by default). Each slot pairs a 64-bit tag with a 64-bit translation word. Bit 63 of the translation word marks the slot as valid, and bit 6 marks it as locked against replacement. A host drives the block through a single command port: an operation code, an address and a data word. Each accepted command is answered one cycle later by a single-cycle done strobe, together with the result flags and read data.

There are four operations:

- **Register write** loads the staged tag register.
- **Insert** places the staged tag and the supplied translation word into a slot that the block chooses itself.
- **Indexed write** overwrites a slot that the host names, using the staged tag and the supplied translation word.
- **Lookup** searches for a valid slot whose tag equals the supplied word.

The insert does not use LRU or random replacement. It takes the lowest-numbered invalid slot. If every slot is valid, it takes the lowest-numbered unlocked slot. It never displaces a locked slot.

Top module: `tlb_lockfill`

## Requirements
- R1: After reset every slot is invalid. `done_o`, `miss_o`, `ins_fail_o` and `rdata_o` are all 0. A lookup of any value, including 0, reports a miss.
- R2: A command presented with `cmd_valid_i` high at a rising edge produces `done_o` high for exactly the next cycle. `done_o` is low in every cycle that does not follow an accepted command.
- R3: Register write (`cmd_op_i` = 0) loads `wdata_i` into the staged tag register only when address bits 6:3 equal 6. Any other register select leaves the staged tag unchanged.
- R4: Insert (`cmd_op_i` = 1) writes the staged tag and `wdata_i` into the lowest-indexed slot whose translation bit 63 is 0.
- R5: When no slot is invalid, insert writes into the lowest-indexed slot whose translation bit 6 is 0.
- R6: When every slot is both valid and locked, insert changes no slot and reports `ins_fail_o` = 1.
- R7: Indexed write (`cmd_op_i` = 2) overwrites the slot given by address bits 8:3 with the staged tag and `wdata_i`. This happens even when that slot is locked.
- R8: Lookup (`cmd_op_i` = 3) returns, on `rdata_o`, the tag of the lowest-indexed valid slot whose tag equals `wdata_i`, with `miss_o` = 0. With no such slot it returns 0 and `miss_o` = 1.
- R9: A slot whose bit 63 is 0 never matches a lookup, even when its tag equals the searched value.
- R10: `miss_o` can be 1 only after a lookup, and `ins_fail_o` can be 1 only after an insert. Each completed command refreshes both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command accepted at this edge |
| cmd_op_i | input | 2 | 0 register write, 1 insert, 2 indexed write, 3 lookup |
| addr_i | input | 16 | Bits 6:3 select a register; bits 8:3 select a slot |
| wdata_i | input | 64 | Translation word, register value or lookup key |
| done_o | output | 1 | One-cycle completion strobe |
| rdata_o | output | 64 | Tag returned by a lookup hit, otherwise 0 |
| miss_o | output | 1 | Lookup found no valid match |
| ins_fail_o | output | 1 | Insert found no replaceable slot |

## Verification
The insert is exercised in three states of occupancy:

- An empty buffer shows that the first free slot is chosen.
- A full buffer with a locked prefix shows that the first unlocked slot after that prefix is chosen.
- A buffer that is full and fully locked shows that the insert is refused.

Because lookups return only the tag, slot placement is observed indirectly: an indexed write overwrites a specific slot, and later lookups then show whether a given tag has disappeared. Lookups are also run against an invalid slot that carries an equal tag, which separates tag equality from true validity. A write to a register select other than 6 shows that the staged tag is left untouched.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned TW        = 64;
  localparam int unsigned VALID_BIT = 63;
  localparam int unsigned LOCK_BIT  = 6;
  localparam int unsigned TAG_REG   = 6;

  typedef enum logic [1:0] {
    OP_REG_WR = 2'd0,
    OP_INSERT = 2'd1,
    OP_IDX_WR = 2'd2,
    OP_LOOKUP = 2'd3
  } tlb_op_e;
endpackage

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int unsigned N = 64,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/tlb_slot_array.sv
module tlb_slot_array #(
  parameter int unsigned N  = 64,
  parameter int unsigned TW = 64,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [TW-1:0] wtag_i,
  input  logic [TW-1:0] wtte_i,
  output logic [TW-1:0] tag_o [N],
  output logic [TW-1:0] tte_o [N]
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_o[g] <= '0;
        tte_o[g] <= '0;
      end else if (we_i && widx_i == IW'(g)) begin
        tag_o[g] <= wtag_i;
        tte_o[g] <= wtte_i;
      end
    end
  end
endmodule

// File: rtl/tlb_lockfill.sv
module tlb_lockfill
  import tlb_pkg::*;
#(
  parameter int unsigned N      = 64,
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned IW    = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TW-1:0]     wdata_i,
  output logic              done_o,
  output logic [TW-1:0]     rdata_o,
  output logic              miss_o,
  output logic              ins_fail_o
);
  logic [TW-1:0] tag_q [N];
  logic [TW-1:0] tte_q [N];
  logic [TW-1:0] stage_q;
  logic [N-1:0]  free_vec, unlk_vec, hit_vec;
  logic [IW-1:0] free_idx, unlk_idx, hit_idx, ins_idx, wr_idx;
  logic          free_any, unlk_any, hit_any, ins_ok, we;
  logic [3:0]    reg_sel;
  tlb_op_e       op;

  assign op      = tlb_op_e'(cmd_op_i);
  assign reg_sel = addr_i[6:3];

  for (genvar g = 0; g < N; g++) begin : g_vec
    assign free_vec[g] = ~tte_q[g][VALID_BIT];
    assign unlk_vec[g] = ~tte_q[g][LOCK_BIT];
    assign hit_vec[g]  = tte_q[g][VALID_BIT] && (tag_q[g] == wdata_i);
  end

  tlb_prio_enc #(.N(N)) i_enc_free (.req_i(free_vec), .idx_o(free_idx), .any_o(free_any));
  tlb_prio_enc #(.N(N)) i_enc_unlk (.req_i(unlk_vec), .idx_o(unlk_idx), .any_o(unlk_any));
  tlb_prio_enc #(.N(N)) i_enc_hit  (.req_i(hit_vec),  .idx_o(hit_idx),  .any_o(hit_any));

  // invalid slots take precedence over unlocked ones
  assign ins_idx = free_any ? free_idx : unlk_idx;
  assign ins_ok  = free_any | unlk_any;
  assign wr_idx  = (op == OP_IDX_WR) ? addr_i[IW+2:3] : ins_idx;
  assign we      = cmd_valid_i && ((op == OP_INSERT && ins_ok) || op == OP_IDX_WR);

  tlb_slot_array #(.N(N), .TW(TW)) i_slots (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .widx_i (wr_idx),
    .wtag_i (stage_q),
    .wtte_i (wdata_i),
    .tag_o  (tag_q),
    .tte_o  (tte_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else if (cmd_valid_i && op == OP_REG_WR && reg_sel == 4'(TAG_REG)) begin
      stage_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      rdata_o    <= '0;
      miss_o     <= 1'b0;
      ins_fail_o <= 1'b0;
    end else begin
      done_o <= cmd_valid_i;
      if (cmd_valid_i) begin
        rdata_o    <= (op == OP_LOOKUP && hit_any) ? tag_q[hit_idx] : '0;
        miss_o     <= (op == OP_LOOKUP) && !hit_any;
        ins_fail_o <= (op == OP_INSERT) && !ins_ok;
      end
    end
  end
endmodule

// File: rtl/tlb_lockfill_chk.sv
module tlb_lockfill_chk
  import tlb_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [1:0]        cmd_op_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [TW-1:0]     wdata_i,
  input logic              done_o,
  input logic [TW-1:0]     rdata_o,
  input logic              miss_o,
  input logic              ins_fail_o
);
  logic unused_addr;
  assign unused_addr = ^addr_i;

  p_done_follows_cmd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> done_o);

  p_no_spurious_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !done_o);

  p_hit_returns_key_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_op_i == OP_LOOKUP |=> (miss_o || rdata_o == $past(wdata_i)));

  p_miss_zero_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && miss_o |-> rdata_o == '0);

  p_miss_only_lookup_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_op_i != OP_LOOKUP |=> !miss_o);

  p_fail_only_insert_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_op_i != OP_INSERT |=> !ins_fail_o);
endmodule

bind tlb_lockfill tlb_lockfill_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .done_o      (done_o),
  .rdata_o     (rdata_o),
  .miss_o      (miss_o),
  .ins_fail_o  (ins_fail_o)
);

// File: tb/test_tlb_lockfill.sv
module test_tlb_lockfill;
  localparam logic [63:0] V = 64'h8000_0000_0000_0000;
  localparam logic [63:0] L = 64'h0000_0000_0000_0040;

  typedef struct {
    logic [63:0] rdata;
    logic        miss;
    logic        fail;
    string       req;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [1:0]  cmd_op_i = '0;
  logic [15:0] addr_i = '0;
  logic [63:0] wdata_i = '0;
  logic        done_o, miss_o, ins_fail_o;
  logic [63:0] rdata_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;
  exp_t sb_q[$];

  always #5 clk_i = ~clk_i;

  tlb_lockfill i_tlb_lockfill (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .done_o(done_o), .rdata_o(rdata_o),
    .miss_o(miss_o), .ins_fail_o(ins_fail_o)
  );

  function automatic logic [63:0] tag_of(int i);
    return 64'h5A00_0000_0000_0000 + 64'(i) * 64'h1000;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_op(logic [1:0] op, logic [15:0] addr, logic [63:0] wd,
                       logic [63:0] er, bit em, bit ef, string req);
    exp_t e;
    e.rdata = er; e.miss = em; e.fail = ef; e.req = req;
    sb_q.push_back(e);
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = op; addr_i = addr; wdata_i = wd;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    @(negedge clk_i);
    chk(done_o == 1'b0, "R2 done single cycle", 64'(done_o), 64'd0);
  endtask

  task automatic set_tag(logic [63:0] t, string req);
    do_op(2'd0, 16'(6 << 3), t, 64'd0, 1'b0, 1'b0, req);
  endtask
  task automatic insert(logic [63:0] tte, bit ef, string req);
    do_op(2'd1, 16'd0, tte, 64'd0, 1'b0, ef, req);
  endtask
  task automatic idx_wr(int slot, logic [63:0] tte, string req);
    do_op(2'd2, 16'(slot << 3), tte, 64'd0, 1'b0, 1'b0, req);
  endtask
  task automatic lookup(logic [63:0] key, bit hit, string req);
    do_op(2'd3, 16'd0, key, hit ? key : 64'd0, !hit, 1'b0, req);
  endtask

  // monitor: pop scoreboard on every done strobe
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && done_o) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R2 unexpected done", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(rdata_o == e.rdata, {e.req, " rdata"}, rdata_o, e.rdata);
          chk(miss_o == e.miss, {e.req, " miss"}, 64'(miss_o), 64'(e.miss));
          chk(ins_fail_o == e.fail, {e.req, " ins_fail"}, 64'(ins_fail_o), 64'(e.fail));
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 150000 && !finished) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected below 150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(done_o == 0 && miss_o == 0 && ins_fail_o == 0 && rdata_o == 0,
        "R1 reset outputs", {rdata_o[60:0], done_o, miss_o, ins_fail_o}, 64'd0);
    rst_ni = 1'b1;
    lookup(64'd0, 1'b0, "R1 zero key misses after reset");

    set_tag(tag_of(100), "R3 stage A");
    insert(V, 1'b0, "R4 insert into empty");
    lookup(tag_of(100), 1'b1, "R8 hit A");
    set_tag(tag_of(101), "R3 stage C");
    idx_wr(0, V, "R7 overwrite slot 0");
    lookup(tag_of(100), 1'b0, "R4 A was in slot 0");
    lookup(tag_of(101), 1'b1, "R7 C in slot 0");

    do_op(2'd0, 16'(5 << 3), tag_of(102), 64'd0, 1'b0, 1'b0, "R3 other select");
    insert(V, 1'b0, "R4 insert into slot 1");
    lookup(tag_of(102), 1'b0, "R3 select 5 ignored");
    set_tag(tag_of(103), "R3 stage D");
    idx_wr(2, 64'd0, "R9 invalid slot with tag D");
    lookup(tag_of(103), 1'b0, "R9 invalid tag no match");

    // fill: slots 2..63 by insert, slots 0..9 locked
    for (int i = 2; i < 64; i++) begin
      set_tag(tag_of(i), "R3 fill stage");
      insert(V | ((i < 10) ? L : 64'd0), 1'b0, "R4 fill insert");
    end
    for (int i = 0; i < 2; i++) begin
      set_tag(tag_of(i), "R3 fill stage");
      idx_wr(i, V | L, "R7 lock low slot");
    end
    lookup(tag_of(5), 1'b1, "R4 fill order slot 5");
    lookup(tag_of(63), 1'b1, "R4 fill order slot 63");

    set_tag(tag_of(200), "R3 stage Z");
    insert(V, 1'b0, "R5 insert when full");
    lookup(tag_of(10), 1'b0, "R5 first unlocked slot 10 replaced");
    lookup(tag_of(9), 1'b1, "R5 locked slot 9 kept");
    lookup(tag_of(11), 1'b1, "R5 slot 11 kept");
    lookup(tag_of(200), 1'b1, "R5 Z present");

    for (int i = 10; i < 64; i++) begin
      set_tag(tag_of(i), "R3 relock stage");
      idx_wr(i, V | L, "R7 lock slot");
    end
    set_tag(tag_of(300), "R3 stage Y");
    insert(V, 1'b1, "R6 all locked insert fails");
    lookup(tag_of(300), 1'b0, "R6 dropped insert absent");
    lookup(tag_of(10), 1'b1, "R6 no eviction; R10 fail flag cleared");
    lookup(tag_of(63), 1'b1, "R6 slot 63 kept");

    set_tag(tag_of(400), "R3 stage W");
    idx_wr(5, V | L, "R7 overwrite locked slot");
    lookup(tag_of(5), 1'b0, "R7 old tag gone");
    lookup(tag_of(400), 1'b1, "R7 new tag present");

    repeat (4) @(negedge clk_i);
    chk(sb_q.size() == 0, "R2 all commands completed", 64'(sb_q.size()), 64'd0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule